// File: doc/BRIEF.md
# Block-Cipher Configuration Register File with Key Lock

This block is the software-facing control store of a block-cipher accelerator. A processor reaches it through a simple 32-bit register port: one write strobe, a word address and write data, with read data returned combinationally for the addressed word. The block holds the operating configuration (key length, chaining mode, direction, byte-swap enables, DMA enable and cascade), the eight key words, the four IV words and the DMA source, destination and byte-count values. It also turns the start and stop bits into single-cycle pulses for the engine.

Three properties set it apart from a plain register bank. The key words can be locked against read-back; the lock is released only by one 5-bit code, and that release also erases the key. While the engine reports busy, the configuration fields are frozen, so a running operation never sees its mode change under it. The DMA address and count registers are double-stored: software writes a shadow copy at any time, and the working copy driven to the engine follows the shadow only while the engine is idle, so the values written during a run apply to the next one.

A small state machine tracks each operation. ST_IDLE moves to ST_ARMED when a start is accepted, ST_ARMED moves to ST_ACTIVE when the engine raises busy, and ST_ACTIVE returns to ST_IDLE when busy falls. A start is accepted only in ST_IDLE with busy low.

Top module: `cipher_cfg_regs`

## Requirements
- R1: Writing CTRL (word 0) with bit 0 set, while idle and not busy, raises `eng_start` for exactly one cycle; bit 1 raises `eng_stop` for one cycle; both bits always read back 0, and a start written while busy gives no pulse.
- R2: Writing CTRL bit 31 = 1 sets the key lock; while locked, reads of the key words (words 8 to 15) return 0 and CTRL bit 31 reads 1.
- R3: The lock clears only on a CTRL write with bit 31 = 0 and bits 30:26 = 10110; that write also clears all eight key words. Any other code in bits 30:26 leaves the lock set; bits 30:26 read back as last written.
- R4: While `eng_busy` is 1, CTRL writes leave key size (bits 3:2), mode (15:8), direction (16), output swap (22), input swap (23), DMA enable (7), cascade (6), unlock code and lock bit unchanged, both in read-back and on the `cfg_*` outputs.
- R5: CTRL bits 15:8 drive `cfg_mode` unchanged for the codes 0x00 ECB, 0x01 CBC, 0x02 CFB, 0x03 OFB, 0x04 CTR, 0x10, 0x11 and 0x12 (the three ciphertext-stealing CBC variants); bit 16 = 1 selects encryption, bit 22 output swap, bit 23 input swap.
- R6: CTRL bit 5 (last block) reads back 0; once written it holds `cfg_last` at 1 until the next accepted start, which reloads it from that start write's bit 5.
- R7: The source (word 2) and destination (word 3) addresses store and read back with bits 1:0 forced to 0; the count (word 4) keeps all 32 bits.
- R8: The working copies `dma_src`, `dma_dst`, `dma_cnt` take the shadow value one cycle after a write while busy is low, and do not change while busy is high; the new value appears the cycle after busy falls.
- R9: An accepted start with DMA enable set and a working byte count of 0 sets the count-error flag (STATUS bit 12); an accepted start with a non-zero count or DMA disabled clears it.
- R10: After reset all registers read 0; STATUS (word 1) bit 0 reflects `eng_busy`; IV words are 16 to 19; an unmapped word reads 0 and ignores writes; the run state returns to ST_IDLE the cycle after busy falls in ST_ACTIVE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| eng_busy | input | 1 | Busy indication from the cipher engine |
| eng_start | output | 1 | One-cycle start pulse |
| eng_stop | output | 1 | One-cycle stop pulse |
| cfg_key_size | output | 2 | Key length selection |
| cfg_mode | output | 8 | Chaining mode code |
| cfg_encrypt | output | 1 | 1 = encrypt, 0 = decrypt |
| cfg_in_swap | output | 1 | Input byte-order swap |
| cfg_out_swap | output | 1 | Output byte-order swap |
| cfg_dma_en | output | 1 | DMA transfer enable |
| cfg_cascade | output | 1 | DMA cascade enable |
| cfg_last | output | 1 | Last-block marker |
| cfg_key | output | 256 | Key, word 0 in the low bits |
| cfg_iv | output | 128 | IV, word 0 in the low bits |
| dma_src | output | 32 | Working DMA source address |
| dma_dst | output | 32 | Working DMA destination address |
| dma_cnt | output | 32 | Working DMA byte count |
| cnt_err | output | 1 | Count-error flag |

## Verification
The hardest situations to reach are the ones that need the engine busy at the moment of a write: the frozen configuration, the refused start, and the shadow address held back from the working copy. The bench drives `eng_busy` from a stub engine that answers each start pulse with a busy window of twenty cycles, then issues configuration, lock and address writes inside that window and checks both read-back and outputs before and after busy falls. The lock is driven through a wrong code before the correct one, so that the erase is seen only on the right code.

// File: rtl/cipher_cfg_pkg.sv
package cipher_cfg_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'd1;
    localparam logic [ADDR_W-1:0] A_SRC    = 5'd2;
    localparam logic [ADDR_W-1:0] A_DST    = 5'd3;
    localparam logic [ADDR_W-1:0] A_CNT    = 5'd4;
    localparam logic [ADDR_W-1:0] KEY_BASE = 5'd8;
    localparam logic [ADDR_W-1:0] IV_BASE  = 5'd16;

    localparam logic [4:0] UNLOCK_CODE = 5'b10110;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2
    } run_state_e;
endpackage

// File: rtl/cfg_run_fsm.sv
module cfg_run_fsm
    import cipher_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       eng_busy,
    output logic       start_ok,
    output logic       eng_start,
    output logic       eng_stop,
    output run_state_e state
);
    run_state_e nxt;

    assign start_ok = start_req && (state == ST_IDLE) && !eng_busy;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start_ok) nxt = ST_ARMED;
            ST_ARMED:  if (eng_busy) nxt = ST_ACTIVE;
            ST_ACTIVE: if (!eng_busy) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            eng_stop  <= 1'b0;
        end else begin
            eng_start <= start_ok;
            eng_stop  <= stop_req;
        end
    end

    // R1
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    // R1
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(state) == ST_IDLE);
    // R10
    active_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !eng_busy) |=> state == ST_IDLE);
endmodule

// File: rtl/cfg_key_store.sv
module cfg_key_store #(
    parameter int NKEY = 8,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NKEY)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic               prot_set,
    input  logic               unlock,
    input  logic [IW-1:0]      rd_idx,
    output logic [DW-1:0]      rd_data,
    output logic               prot,
    output logic [NKEY*DW-1:0] key_flat
);
    logic [DW-1:0] kw [NKEY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot <= 1'b0;
            for (int i = 0; i < NKEY; i++) kw[i] <= '0;
        end else if (unlock) begin
            prot <= 1'b0;
            for (int i = 0; i < NKEY; i++) kw[i] <= '0;
        end else begin
            if (prot_set) prot <= 1'b1;
            if (wr_en) kw[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < NKEY; g++) begin : g_flat
        assign key_flat[g*DW +: DW] = kw[g];
    end

    assign rd_data = prot ? '0 : kw[rd_idx];

    // R3
    unlock_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot) |-> key_flat == '0);
endmodule

// File: rtl/cfg_dma_shadow.sv
module cfg_dma_shadow #(
    parameter int AW  = 32,
    parameter int LOW = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          eng_busy,
    output logic [AW-1:0] shadow,
    output logic [AW-1:0] working
);
    localparam logic [AW-1:0] KEEP = {AW{1'b1}} << LOW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow  <= '0;
            working <= '0;
        end else begin
            if (wr_en)     shadow  <= wr_data & KEEP;
            if (!eng_busy) working <= shadow;
        end
    end

    // R8
    work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eng_busy) |-> $stable(working));
    // R8
    work_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(eng_busy) |-> working == $past(shadow));
endmodule

// File: rtl/cipher_cfg_regs.sv
module cipher_cfg_regs
    import cipher_cfg_pkg::*;
#(
    parameter int NKEY = 8,
    parameter int NIV  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic                   eng_busy,
    output logic                   eng_start,
    output logic                   eng_stop,
    output logic [1:0]             cfg_key_size,
    output logic [7:0]             cfg_mode,
    output logic                   cfg_encrypt,
    output logic                   cfg_in_swap,
    output logic                   cfg_out_swap,
    output logic                   cfg_dma_en,
    output logic                   cfg_cascade,
    output logic                   cfg_last,
    output logic [NKEY*DATA_W-1:0] cfg_key,
    output logic [NIV*DATA_W-1:0]  cfg_iv,
    output logic [DATA_W-1:0]      dma_src,
    output logic [DATA_W-1:0]      dma_dst,
    output logic [DATA_W-1:0]      dma_cnt,
    output logic                   cnt_err
);
    localparam int KIW = $clog2(NKEY);
    localparam int VIW = $clog2(NIV);
    localparam logic [ADDR_W-1:0] KEY_LAST = KEY_BASE + ADDR_W'(NKEY - 1);
    localparam logic [ADDR_W-1:0] IV_LAST  = IV_BASE + ADDR_W'(NIV - 1);

    logic wr_ctrl, start_ok, cfg_open, key_sel, iv_sel, key_prot;
    logic [4:0] unlock_r;
    logic [KIW-1:0] key_idx;
    logic [VIW-1:0] iv_idx;
    logic [DATA_W-1:0] key_rd, src_sh, dst_sh, cnt_sh;
    logic [DATA_W-1:0] iv_r [NIV];
    run_state_e run_state;
    logic unused_wbits;

    assign unused_wbits = ^{reg_wdata[25:24], reg_wdata[21:17], reg_wdata[4]};

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign cfg_open = wr_ctrl && !eng_busy;
    assign key_sel  = (reg_addr >= KEY_BASE) && (reg_addr <= KEY_LAST);
    assign iv_sel   = (reg_addr >= IV_BASE) && (reg_addr <= IV_LAST);
    assign key_idx  = KIW'(reg_addr - KEY_BASE);
    assign iv_idx   = VIW'(reg_addr - IV_BASE);

    cfg_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_req(wr_ctrl && reg_wdata[0]),
        .stop_req(wr_ctrl && reg_wdata[1]),
        .eng_busy(eng_busy), .start_ok(start_ok),
        .eng_start(eng_start), .eng_stop(eng_stop), .state(run_state)
    );

    cfg_key_store #(.NKEY(NKEY), .DW(DATA_W)) u_keys (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && key_sel), .wr_idx(key_idx), .wr_data(reg_wdata),
        .prot_set(cfg_open && reg_wdata[31]),
        .unlock(cfg_open && !reg_wdata[31] && (reg_wdata[30:26] == UNLOCK_CODE)),
        .rd_idx(key_idx), .rd_data(key_rd), .prot(key_prot), .key_flat(cfg_key)
    );

    cfg_dma_shadow #(.AW(DATA_W), .LOW(2)) u_src (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && reg_addr == A_SRC),
        .wr_data(reg_wdata), .eng_busy(eng_busy), .shadow(src_sh), .working(dma_src));
    cfg_dma_shadow #(.AW(DATA_W), .LOW(2)) u_dst (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && reg_addr == A_DST),
        .wr_data(reg_wdata), .eng_busy(eng_busy), .shadow(dst_sh), .working(dma_dst));
    cfg_dma_shadow #(.AW(DATA_W), .LOW(0)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && reg_addr == A_CNT),
        .wr_data(reg_wdata), .eng_busy(eng_busy), .shadow(cnt_sh), .working(dma_cnt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_key_size <= '0;
            cfg_mode     <= '0;
            cfg_encrypt  <= 1'b0;
            cfg_in_swap  <= 1'b0;
            cfg_out_swap <= 1'b0;
            cfg_dma_en   <= 1'b0;
            cfg_cascade  <= 1'b0;
            unlock_r     <= '0;
        end else if (cfg_open) begin
            cfg_key_size <= reg_wdata[3:2];
            cfg_mode     <= reg_wdata[15:8];
            cfg_encrypt  <= reg_wdata[16];
            cfg_out_swap <= reg_wdata[22];
            cfg_in_swap  <= reg_wdata[23];
            cfg_dma_en   <= reg_wdata[7];
            cfg_cascade  <= reg_wdata[6];
            unlock_r     <= reg_wdata[30:26];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_last <= 1'b0;
            cnt_err  <= 1'b0;
        end else if (start_ok) begin
            cfg_last <= reg_wdata[5];
            cnt_err  <= reg_wdata[7] && (cnt_sh == '0);
        end else if (wr_ctrl && reg_wdata[5]) begin
            cfg_last <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NIV; i++) iv_r[i] <= '0;
        end else if (reg_wr && iv_sel) begin
            iv_r[iv_idx] <= reg_wdata;
        end
    end

    for (genvar g = 0; g < NIV; g++) begin : g_iv
        assign cfg_iv[g*DATA_W +: DATA_W] = iv_r[g];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL)
            reg_rdata = {key_prot, unlock_r, 2'b00, cfg_in_swap, cfg_out_swap, 5'b0,
                         cfg_encrypt, cfg_mode, cfg_dma_en, cfg_cascade, 2'b00,
                         cfg_key_size, 2'b00};
        else if (reg_addr == A_STAT) reg_rdata = {19'b0, cnt_err, 11'b0, eng_busy};
        else if (reg_addr == A_SRC)  reg_rdata = src_sh;
        else if (reg_addr == A_DST)  reg_rdata = dst_sh;
        else if (reg_addr == A_CNT)  reg_rdata = cnt_sh;
        else if (key_sel)            reg_rdata = key_rd;
        else if (iv_sel)             reg_rdata = iv_r[iv_idx];
    end

    // R4
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eng_busy) |-> ($stable(cfg_mode) && $stable(cfg_key_size) &&
                             $stable(cfg_encrypt) && $stable(cfg_dma_en) &&
                             $stable(key_prot) && $stable(unlock_r)));
    // R2
    key_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_prot && key_sel) |-> reg_rdata == '0);
    // R9
    cnt_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_err) |-> (cfg_dma_en && dma_cnt == '0 && run_state == ST_ARMED));
endmodule

// File: tb/tb_cipher_cfg_regs.sv
`timescale 1ns/1ps
module tb_cipher_cfg_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         eng_busy;
    logic         eng_start, eng_stop;
    logic [1:0]   cfg_key_size;
    logic [7:0]   cfg_mode;
    logic         cfg_encrypt, cfg_in_swap, cfg_out_swap, cfg_dma_en, cfg_cascade, cfg_last;
    logic [255:0] cfg_key;
    logic [127:0] cfg_iv;
    logic [31:0]  dma_src, dma_dst, dma_cnt;
    logic         cnt_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int stub_cnt = 0;
    localparam int STUB_LEN = 20;

    always #5 clk = ~clk;

    cipher_cfg_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .eng_start(eng_start), .eng_stop(eng_stop), .cfg_key_size(cfg_key_size),
        .cfg_mode(cfg_mode), .cfg_encrypt(cfg_encrypt), .cfg_in_swap(cfg_in_swap),
        .cfg_out_swap(cfg_out_swap), .cfg_dma_en(cfg_dma_en), .cfg_cascade(cfg_cascade),
        .cfg_last(cfg_last), .cfg_key(cfg_key), .cfg_iv(cfg_iv), .dma_src(dma_src),
        .dma_dst(dma_dst), .dma_cnt(dma_cnt), .cnt_err(cnt_err)
    );

    // stub engine: busy for STUB_LEN cycles after each start pulse
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_busy <= 1'b0;
            stub_cnt <= 0;
        end else if (eng_start) begin
            eng_busy <= 1'b1;
            stub_cnt <= STUB_LEN;
        end else if (eng_busy) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) eng_busy <= 1'b0;
        end
    end

    // address, write data, expected read-back
    localparam logic [68:0] VEC [9] = '{
        {5'd0,  32'h00C1_122E, 32'h00C1_120C},
        {5'd0,  32'h0C00_0380, 32'h0C00_0380},
        {5'd2,  32'h1000_0007, 32'h1000_0004},
        {5'd3,  32'hABCD_EF13, 32'hABCD_EF10},
        {5'd4,  32'h0000_0040, 32'h0000_0040},
        {5'd8,  32'h0123_4567, 32'h0123_4567},
        {5'd15, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {5'd19, 32'hCAFE_F00D, 32'hCAFE_F00D},
        {5'd7,  32'h5555_AAAA, 32'h0000_0000}
    };
    localparam logic [7:0] MODES [8] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h10, 8'h11, 8'h12};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        while (eng_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(5'd0, r);  chk("R10 reset CTRL", r, 32'h0);
        rd(5'd1, r);  chk("R10 reset STATUS", r, 32'h0);
        chk("R10 reset eng_start", {31'b0, eng_start}, 32'h0);
        chk("R10 reset dma_src", dma_src, 32'h0);

        // table: R5 R7 R10 read-back
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][68:64], VEC[i][63:32]);
            rd(VEC[i][68:64], r);
            chk($sformatf("R7 R10 vector %0d", i), r, VEC[i][31:0]);
        end
        @(negedge clk);
        chk("R8 src follows idle", dma_src, 32'h1000_0004);
        chk("R8 dst follows idle", dma_dst, 32'hABCD_EF10);
        chk("R8 cnt follows idle", dma_cnt, 32'h0000_0040);
        chk("R10 key word0 out", cfg_key[31:0], 32'h0123_4567);
        chk("R10 key word7 out", cfg_key[255:224], 32'hDEAD_BEEF);
        chk("R10 iv word3 out", cfg_iv[127:96], 32'hCAFE_F00D);

        // R5 mode codes and direction
        for (int m = 0; m < 8; m++) begin
            wr(5'd0, 32'h0001_0000 | (32'(MODES[m]) << 8));
            chk($sformatf("R5 mode %h", MODES[m]), {24'b0, cfg_mode}, {24'b0, MODES[m]});
            chk("R5 encrypt", {31'b0, cfg_encrypt}, 32'h1);
        end
        wr(5'd0, 32'h00C0_0000);
        chk("R5 swaps", {29'b0, cfg_in_swap, cfg_out_swap, cfg_encrypt}, 32'h6);

        // R6 last block
        wr(5'd0, 32'h0000_0020);
        chk("R6 last set", {31'b0, cfg_last}, 32'h1);
        rd(5'd0, r);  chk("R6 last reads 0", r, 32'h0);

        // R1 stop pulse
        wr(5'd0, 32'h0000_0002);
        chk("R1 stop pulse", {31'b0, eng_stop}, 32'h1);
        chk("R6 last held", {31'b0, cfg_last}, 32'h1);
        @(negedge clk);
        chk("R1 stop one cycle", {31'b0, eng_stop}, 32'h0);

        // R1 start pulse, CBC mode
        wr(5'd0, 32'h0000_0101);
        chk("R1 start pulse", {31'b0, eng_start}, 32'h1);
        chk("R6 last cleared by start", {31'b0, cfg_last}, 32'h0);
        @(negedge clk);
        chk("R1 start one cycle", {31'b0, eng_start}, 32'h0);
        rd(5'd1, r);  chk("R10 status busy", r, 32'h1);
        rd(5'd0, r);  chk("R1 start reads 0", r, 32'h0000_0100);

        // R4 frozen while busy, R1 start refused while busy
        wr(5'd0, 32'h0000_1208);
        rd(5'd0, r);  chk("R4 ctrl frozen", r, 32'h0000_0100);
        chk("R4 mode output frozen", {24'b0, cfg_mode}, 32'h01);
        wr(5'd0, 32'h0000_0001);
        chk("R1 no start while busy", {31'b0, eng_start}, 32'h0);

        // R8 shadow during busy
        wr(5'd2, 32'h2000_0003);
        rd(5'd2, r);  chk("R7 shadow aligned", r, 32'h2000_0000);
        chk("R8 working held", dma_src, 32'h1000_0004);
        wait_idle();
        chk("R8 working after busy", dma_src, 32'h2000_0000);
        wr(5'd0, 32'h0000_1208);
        chk("R4 write after idle", {24'b0, cfg_mode}, 32'h12);

        // R9 count error
        wr(5'd4, 32'h0);
        wr(5'd0, 32'h0000_0081);
        @(negedge clk);
        rd(5'd1, r);  chk("R9 count error set", r, 32'h0000_1001);
        wait_idle();
        wr(5'd4, 32'd16);
        wr(5'd0, 32'h0000_0081);
        @(negedge clk);
        rd(5'd1, r);  chk("R9 count error cleared", r, 32'h0000_0001);
        wait_idle();

        // R2 R3 key lock
        wr(5'd8, 32'h1111_2222);
        wr(5'd11, 32'h3333_4444);
        wr(5'd0, 32'h8000_0000);
        rd(5'd8, r);  chk("R2 key hidden", r, 32'h0);
        rd(5'd0, r);  chk("R2 lock reads 1", r, 32'h8000_0000);
        wr(5'd0, 32'h5C00_0000);
        rd(5'd0, r);  chk("R3 wrong code keeps lock", r, 32'hDC00_0000);
        rd(5'd11, r); chk("R3 still hidden", r, 32'h0);
        chk("R3 key kept on wrong code", cfg_key[127:96], 32'h3333_4444);
        wr(5'd0, 32'h5800_0000);
        rd(5'd0, r);  chk("R3 unlock", r, 32'h5800_0000);
        rd(5'd11, r); chk("R3 key wiped read", r, 32'h0);
        chk("R3 key wiped out", cfg_key[127:96], 32'h0);
        wr(5'd11, 32'h0000_0055);
        rd(5'd11, r); chk("R3 key writable again", r, 32'h55);

        // R4 lock bit ignored while busy
        wr(5'd0, 32'h0000_0001);
        @(negedge clk);
        wr(5'd0, 32'h8000_0000);
        rd(5'd0, r);  chk("R4 lock ignored busy", r, 32'h0);
        rd(5'd11, r); chk("R4 key visible", r, 32'h55);
        wait_idle();

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        done = 1'b1;
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule